// File: doc/BRIEF.md
# Banked Memory Mapper with Access Wait Control

This block sits between a CPU with a 16-bit address bus and a physical memory system made of 64 blocks of 8 KB each. The CPU address space is split into eight equal windows, and each window has a slot register that names the physical block the window currently shows. Software programs the slots through an index/data register pair. The index moves forward by one after every data-port access, so a run of eight data writes or reads sweeps the whole slot file.

For every CPU memory access the block returns the physical block number and the 13-bit offset inside that block. It also holds the CPU with a wait request for the number of extra cycles that the target block's class requires. RAM and ROM blocks only stretch opcode fetches. Video blocks always add one or two cycles. When a video block is reached during the active display period, the wait is first held until blanking starts.

The access side is a valid/ready handshake. An access is taken on a rising clock edge where `acc_valid` and `acc_ready` are both high. `acc_ready` stays low for every cycle in which `wait_req` is high, and a requester seeing it low must hold off. The address mapping outputs follow `acc_addr` combinationally at all times. The register pair and the display flag are plain control pins.

Top module: `mem_bank_mapper`

## Requirements
- R1: After reset the index is 0, slot n holds block n, `wait_req` and `vid_hold` are low, and `acc_ready` is high.
- R2: `phys_blk` equals the slot selected by `acc_addr[15:13]`, and `phys_off` equals `acc_addr[12:0]`, both combinationally.
- R3: A write with `reg_idx_we` loads the index from `reg_wdata[2:0]`. A write with `reg_data_we` stores `reg_wdata[5:0]` into the slot named by the current index, and bits 7:6 are ignored. `reg_rdata` always shows the indexed slot in bits 5:0, with bits 7:6 reading 0.
- R4: Each cycle with `reg_data_we` or `reg_data_re` high advances the index by one, wrapping from 7 to 0. If `reg_idx_we` is high in the same cycle, the loaded value wins and no step is taken.
- R5: Blocks 00h–1Fh (RAM), 34h–37h (boot ROM) and 3Ch–3Fh (communication ROM) add one wait cycle when `acc_m1` is high and none otherwise.
- R6: Blocks 20h–2Fh (plane video) and 38h (text video) add one wait cycle whatever `acc_m1` is.
- R7: Blocks 30h–33h (read-modify-write video) and 39h (pattern/character) add two wait cycles.
- R8: Blocks 3Ah and 3Bh add no wait cycle.
- R9: A video-class block (20h–33h, 38h, 39h) accepted while `disp_active` is high raises `wait_req` and `vid_hold` from the next cycle. They stay high until an edge samples `disp_active` low, and then the class wait cycles of R6/R7 follow with `vid_hold` low.
- R10: `acc_ready` is low whenever `wait_req` is high. A request presented then is not taken and does not change the running wait.
- R11: A non-video block accessed while `disp_active` is high is not held. It gets only its R5/R8 wait, and `vid_hold` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_idx_we | input | 1 | Load the slot index from reg_wdata |
| reg_data_we | input | 1 | Write the indexed slot, then step the index |
| reg_data_re | input | 1 | Data-port read strobe, steps the index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Indexed slot contents, upper bits zero |
| acc_valid | input | 1 | CPU memory access request |
| acc_ready | output | 1 | Block can take an access |
| acc_addr | input | 16 | CPU address |
| acc_m1 | input | 1 | Access is an opcode fetch |
| disp_active | input | 1 | 1 during the display period, 0 in blanking |
| phys_blk | output | 6 | Physical block number |
| phys_off | output | 13 | Offset inside the block |
| wait_req | output | 1 | Stall request to the CPU |
| vid_hold | output | 1 | Video access held for blanking |

## Verification
The hardest case to reach is a video access that lands in the display period. Its stall length depends on how many edges pass before blanking, not on the block alone. The bench keeps the display flag high for a chosen number of edges after the access is taken, then drops it. The scoreboard's expected stall is that hold length plus one plus the class wait. A second hard case pokes a new request into the middle of a running wait, to show that it is refused and that the count is unchanged.

// File: rtl/mbm_pkg.sv
package mbm_pkg;
  localparam int BLK_W  = 6;
  localparam int WAIT_W = 2;

  typedef struct packed {
    logic              video;
    logic              fetch_only;
    logic [WAIT_W-1:0] cycles;
  } wait_rule_t;

  function automatic wait_rule_t lookup_rule(input logic [BLK_W-1:0] b);
    wait_rule_t r;
    r = '{video: 1'b0, fetch_only: 1'b0, cycles: '0};
    if (b[5] == 1'b0) begin
      r.fetch_only = 1'b1; r.cycles = 2'd1;              // main / extended RAM
    end else if (b[4] == 1'b0) begin
      r.video = 1'b1; r.cycles = 2'd1;                   // plane video 20h-2Fh
    end else if (b[3:2] == 2'b00) begin
      r.video = 1'b1; r.cycles = 2'd2;                   // rmw video 30h-33h
    end else if (b[3:2] == 2'b01) begin
      r.fetch_only = 1'b1; r.cycles = 2'd1;              // boot ROM 34h-37h
    end else if (b[3:2] == 2'b11) begin
      r.fetch_only = 1'b1; r.cycles = 2'd1;              // comm ROM 3Ch-3Fh
    end else if (b[1:0] == 2'b00) begin
      r.video = 1'b1; r.cycles = 2'd1;                   // text video 38h
    end else if (b[1:0] == 2'b01) begin
      r.video = 1'b1; r.cycles = 2'd2;                   // pattern block 39h
    end
    return r;                                            // 3Ah/3Bh: no wait
  endfunction
endpackage

// File: rtl/mbm_slot_file.sv
module mbm_slot_file
  import mbm_pkg::*;
#(
  parameter int SLOT_CNT = 8,
  localparam int SLOT_W = $clog2(SLOT_CNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_we,
  input  logic              data_we,
  input  logic              data_re,
  input  logic [BLK_W-1:0]  wdata,
  input  logic [SLOT_W-1:0] idx_wdata,
  input  logic [SLOT_W-1:0] lookup_sel,
  output logic [BLK_W-1:0]  lookup_blk,
  output logic [BLK_W-1:0]  indexed_blk,
  output logic [SLOT_W-1:0] idx_o
);
  logic [SLOT_W-1:0] idx_q;
  logic [BLK_W-1:0]  slot_q [SLOT_CNT];

  always_ff @(posedge clk) begin
    if (!rst_n)                 idx_q <= '0;
    else if (idx_we)            idx_q <= idx_wdata;
    else if (data_we || data_re) idx_q <= idx_q + 1'b1;
  end

  for (genvar n = 0; n < SLOT_CNT; n++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        slot_q[n] <= BLK_W'(n);
      else if (data_we && (idx_q == SLOT_W'(n)))
        slot_q[n] <= wdata;
    end
  end

  assign lookup_blk  = slot_q[lookup_sel];
  assign indexed_blk = slot_q[idx_q];
  assign idx_o       = idx_q;
endmodule

// File: rtl/mbm_wait_rules.sv
module mbm_wait_rules
  import mbm_pkg::*;
(
  input  logic [BLK_W-1:0]  blk,
  input  logic              m1,
  output logic [WAIT_W-1:0] cycles,
  output logic              video
);
  wait_rule_t rule;
  always_comb begin
    rule   = lookup_rule(blk);
    video  = rule.video;
    cycles = (rule.fetch_only && !m1) ? '0 : rule.cycles;
  end
endmodule

// File: rtl/mbm_wait_seq.sv
module mbm_wait_seq
  import mbm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              need_hold,
  input  logic [WAIT_W-1:0] cycles,
  input  logic              disp_active,
  output logic              busy,
  output logic              holding
);
  typedef enum logic [1:0] {ST_IDLE, ST_HOLD, ST_COUNT} st_e;
  st_e               st_q;
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          cnt_q <= cycles;
          if (need_hold)          st_q <= ST_HOLD;
          else if (cycles != '0)  st_q <= ST_COUNT;
        end
        ST_HOLD: if (!disp_active) begin
          st_q <= (cnt_q != '0) ? ST_COUNT : ST_IDLE;
        end
        ST_COUNT: begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q <= WAIT_W'(1)) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (st_q != ST_IDLE);
  assign holding = (st_q == ST_HOLD);
endmodule

// File: rtl/mem_bank_mapper.sv
module mem_bank_mapper
  import mbm_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int SLOT_CNT = 8,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_idx_we,
  input  logic              reg_data_we,
  input  logic              reg_data_re,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_m1,
  input  logic              disp_active,
  output logic [BLK_W-1:0]  phys_blk,
  output logic [ADDR_W-$clog2(SLOT_CNT)-1:0] phys_off,
  output logic              wait_req,
  output logic              vid_hold
);
  localparam int SLOT_W = $clog2(SLOT_CNT);
  localparam int OFF_W  = ADDR_W - SLOT_W;

  logic [SLOT_W-1:0] idx_q;
  logic [BLK_W-1:0]  indexed_blk;
  logic [WAIT_W-1:0] cls_cycles;
  logic              cls_video;
  logic              busy;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:BLK_W];

  mbm_slot_file #(.SLOT_CNT(SLOT_CNT)) u_slots (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx_we     (reg_idx_we),
    .data_we    (reg_data_we),
    .data_re    (reg_data_re),
    .wdata      (reg_wdata[BLK_W-1:0]),
    .idx_wdata  (reg_wdata[SLOT_W-1:0]),
    .lookup_sel (acc_addr[ADDR_W-1 -: SLOT_W]),
    .lookup_blk (phys_blk),
    .indexed_blk(indexed_blk),
    .idx_o      (idx_q)
  );

  mbm_wait_rules u_rules (
    .blk   (phys_blk),
    .m1    (acc_m1),
    .cycles(cls_cycles),
    .video (cls_video)
  );

  mbm_wait_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (acc_valid && acc_ready),
    .need_hold  (cls_video && disp_active),
    .cycles     (cls_cycles),
    .disp_active(disp_active),
    .busy       (busy),
    .holding    (vid_hold)
  );

  assign phys_off  = acc_addr[OFF_W-1:0];
  assign reg_rdata = {{(DATA_W-BLK_W){1'b0}}, indexed_blk};
  assign wait_req  = busy;
  assign acc_ready = !busy;
endmodule

// File: rtl/mbm_checker.sv
module mbm_checker
  import mbm_pkg::*;
#(
  parameter int SLOT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_ready,
  input logic              acc_m1,
  input logic              disp_active,
  input logic [BLK_W-1:0]  phys_blk,
  input logic              wait_req,
  input logic              vid_hold,
  input logic              reg_idx_we,
  input logic              reg_data_we,
  input logic              reg_data_re,
  input logic [SLOT_W-1:0] idx_q
);
  logic take, is_vid;
  assign take   = acc_valid && acc_ready;
  assign is_vid = lookup_rule(phys_blk).video;

  p_idx_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_data_we || reg_data_re) && !reg_idx_we |=> idx_q == SLOT_W'($past(idx_q) + 1'b1));

  p_ram_plain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take && !phys_blk[5] && !acc_m1 |=> !wait_req);

  p_quiet_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take && (phys_blk[5:1] == 5'b11101) |=> !wait_req);

  p_hold_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take && is_vid && disp_active |=> wait_req && vid_hold);

  p_hold_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vid_hold && disp_active |=> vid_hold);

  p_ready_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wait_req |-> !acc_ready);

  p_no_hold_plain_r11: assert property (@(posedge clk) disable iff (!rst_n)
    take && !is_vid |=> !vid_hold);
endmodule

bind mem_bank_mapper mbm_checker #(.SLOT_W(SLOT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_valid  (acc_valid),
  .acc_ready  (acc_ready),
  .acc_m1     (acc_m1),
  .disp_active(disp_active),
  .phys_blk   (phys_blk),
  .wait_req   (wait_req),
  .vid_hold   (vid_hold),
  .reg_idx_we (reg_idx_we),
  .reg_data_we(reg_data_we),
  .reg_data_re(reg_data_re),
  .idx_q      (idx_q)
);

// File: tb/mem_bank_mapper_tb.sv
module mem_bank_mapper_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_idx_we = 0, reg_data_we = 0, reg_data_re = 0;
  logic [7:0]  reg_wdata = 0;
  logic [7:0]  reg_rdata;
  logic        acc_valid = 0, acc_m1 = 0, disp_active = 0;
  logic        acc_ready;
  logic [15:0] acc_addr = 0;
  logic [5:0]  phys_blk;
  logic [12:0] phys_off;
  logic        wait_req, vid_hold;

  int errors = 0;
  int checks = 0;
  int exp_q[$];
  string tag_q[$];
  logic [5:0] tb_slot [8];
  int tb_idx = 0;
  event acc_evt;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_bank_mapper u_dut (
    .clk(clk), .rst_n(rst_n),
    .reg_idx_we(reg_idx_we), .reg_data_we(reg_data_we), .reg_data_re(reg_data_re),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_addr(acc_addr),
    .acc_m1(acc_m1), .disp_active(disp_active),
    .phys_blk(phys_blk), .phys_off(phys_off),
    .wait_req(wait_req), .vid_hold(vid_hold)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int model_wait(input logic [5:0] b, input bit m1);
    if (b <= 6'h1F || (b >= 6'h34 && b <= 6'h37) || b >= 6'h3C) return m1 ? 1 : 0;
    if (b <= 6'h2F || b == 6'h38) return 1;
    if (b <= 6'h33 || b == 6'h39) return 2;
    return 0;
  endfunction

  function automatic bit model_video(input logic [5:0] b);
    return (b >= 6'h20 && b <= 6'h33) || b == 6'h38 || b == 6'h39;
  endfunction

  // scoreboard monitor: counts stall cycles after each taken access
  initial begin
    forever begin
      int cnt;
      int exp;
      string tg;
      @(acc_evt);
      exp = exp_q.pop_front();
      tg  = tag_q.pop_front();
      cnt = 0;
      forever begin
        @(negedge clk);
        if (wait_req) cnt++;
        else break;
      end
      check(cnt == exp, tg, cnt, exp);
    end
  end

  task automatic wr_idx(input int v);
    @(negedge clk);
    reg_idx_we = 1; reg_wdata = 8'(v);
    @(negedge clk);
    reg_idx_we = 0;
    tb_idx = v & 7;
  endtask

  task automatic wr_data(input int v);
    @(negedge clk);
    reg_data_we = 1; reg_wdata = 8'(v);
    @(negedge clk);
    reg_data_we = 0;
    tb_slot[tb_idx] = 6'(v);
    tb_idx = (tb_idx + 1) % 8;
  endtask

  task automatic rd_data(input string tag);
    @(negedge clk);
    reg_data_re = 1;
    #1 check(reg_rdata == {2'b00, tb_slot[tb_idx]}, tag, reg_rdata, tb_slot[tb_idx]);
    @(negedge clk);
    reg_data_re = 0;
    tb_idx = (tb_idx + 1) % 8;
  endtask

  task automatic access(input logic [15:0] a, input bit m1, input bit disp,
                        input int hold_edges, input bit poke, input string tag);
    logic [5:0] eb;
    int w;
    bit held;
    eb   = tb_slot[a[15:13]];
    held = disp && model_video(eb);
    w    = model_wait(eb, m1) + (held ? hold_edges + 1 : 0);
    @(negedge clk);
    acc_valid = 1; acc_addr = a; acc_m1 = m1; disp_active = disp;
    #1;
    check(phys_blk == eb, {tag, " R2 blk"}, phys_blk, eb);
    check(phys_off == a[12:0], {tag, " R2 off"}, phys_off, a[12:0]);
    check(acc_ready == 1'b1, {tag, " R10 ready idle"}, acc_ready, 1);
    exp_q.push_back(w);
    tag_q.push_back({tag, " wait"});
    @(posedge clk);
    -> acc_evt;
    @(negedge clk);
    if (poke) begin
      acc_addr = 16'h0000; acc_m1 = 1;
      #1 check(acc_ready == 1'b0, {tag, " R10 busy refuses"}, acc_ready, 0);
      @(negedge clk);
    end
    acc_valid = 0;
    #1 check(vid_hold == held, {tag, " vid_hold"}, vid_hold, held);
    repeat (hold_edges) @(negedge clk);
    disp_active = 0;
    while (wait_req) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int n = 0; n < 8; n++) tb_slot[n] = 6'(n);
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check(acc_ready == 1 && wait_req == 0 && vid_hold == 0, "R1 idle after reset",
          {acc_ready, wait_req, vid_hold}, 3'b100);
    check(reg_rdata == 8'h00, "R1 index 0 reads slot0", reg_rdata, 0);
    for (int n = 0; n < 8; n++) rd_data("R1 R4 reset slot readback");
    rd_data("R4 index wrap to slot0");

    access(16'h2345, 0, 0, 0, 0, "R2 R5 ram plain");
    access(16'h3FFF, 1, 0, 0, 0, "R5 ram fetch");

    wr_idx(8'hFA);                 // upper bits ignored: index 2
    wr_data(8'h20); wr_data(8'h30); wr_data(8'h38);
    wr_data(8'h39); wr_data(8'h3A); wr_data(8'h34);
    wr_data(8'h3C);                // wrapped to slot0
    wr_data(8'hC5);                // slot1 gets 05h
    wr_idx(1);
    rd_data("R3 upper write bits dropped");

    // index load beats a same-cycle data read step
    @(negedge clk);
    reg_idx_we = 1; reg_wdata = 8'd6; reg_data_re = 1;
    @(negedge clk);
    reg_idx_we = 0; reg_data_re = 0; tb_idx = 6;
    rd_data("R4 index load wins");

    access(16'h0010, 1, 0, 0, 0, "R5 comm rom fetch");
    access(16'h0010, 0, 0, 0, 0, "R5 comm rom data");
    access(16'hE001, 1, 0, 0, 0, "R5 boot rom fetch");
    access(16'h4000, 0, 0, 0, 0, "R6 plane");
    access(16'h8123, 1, 0, 0, 0, "R6 text");
    access(16'h6abc, 0, 0, 0, 0, "R7 rmw");
    access(16'hA000, 1, 0, 0, 0, "R7 pattern");
    access(16'hC000, 1, 0, 0, 0, "R8 dictionary");
    access(16'h6000, 0, 1, 3, 0, "R9 rmw held");
    access(16'h8000, 0, 1, 0, 0, "R9 text held short");
    access(16'h4800, 1, 1, 5, 0, "R9 plane held long");
    access(16'h2000, 0, 1, 2, 0, "R11 ram in display");
    access(16'hE000, 1, 1, 2, 0, "R11 rom in display");
    access(16'h6000, 0, 0, 0, 1, "R10 poke during wait");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule